// File: doc/BRIEF.md
# Sort-then-Route Self-Steering Cell Fabric

This block moves fixed cells from N parallel input ports to N output ports, where N is a power of two (8 by default). Each slot, every input port may offer one cell made of a valid flag, a destination port number and a payload word. The fabric has two parts. The first is a pipelined bitonic sorting network that orders the cells of a slot by destination and places idle ports after all active ones. The second is a butterfly routing network built from 2x2 switching elements. Each element reads one destination bit of the cells it holds and sets itself to bar or cross with no central controller.

Every stage is registered, so a new slot can enter on every clock and each slot leaves after a fixed number of cycles. A routing network used alone blocks internally when two cells bound for different ports need the same internal link. Putting the sorter in front removes those internal collisions. The fabric does not resolve two cells that share a destination in one slot: the surrounding logic must not offer them.

Each switching element has two named settings, `SW_BAR` (pass straight through) and `SW_CROSS` (exchange the two lines). The choice is recomputed every cycle from the data and no other state is held. The latency is LAT = L*(L+1)/2 + L cycles with L = log2 N, which is 9 cycles for N = 8.

Top module: `bb_fabric`

## Requirements
- R1: A valid cell offered on any input with destination d appears on output port d with its payload unchanged. Port i of the flat buses uses bits [i*AW +: AW] of `in_dst` and [i*W +: W] of `in_pay` and `out_pay`.
- R2: Every cell leaves exactly LAT = L*(L+1)/2 + L clock edges after the edge that samples it, where L = log2 N (9 edges for N = 8).
- R3: The number of valid outputs in a cycle equals the number of valid inputs in the slot that entered LAT cycles earlier. Idle inputs produce no valid output.
- R4: While `rst_n` is low, and right after it falls even with cells in flight, every `out_vld` bit is 0.
- R5: Any set of distinct destinations in any input order is delivered without loss or internal collision. This includes full permutations and sparse sets that would block a routing network used alone.
- R6: A new slot is accepted on every clock, so back-to-back slots with different patterns each keep their own routing.
- R7: Within one slot the valid inputs carry distinct destinations. This is an obligation on the user and is checked by an assertion.
- R8: A slot with no valid input yields an all-zero `out_vld` LAT cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | N | Per-port cell present flag |
| in_dst | input | N*AW | Per-port destination number, AW = log2 N |
| in_pay | input | N*W | Per-port payload word |
| out_vld | output | N | Per-port cell delivered flag |
| out_pay | output | N*W | Per-port delivered payload |

## Verification
Sorting and steering act on different slots in the same cycle, and the outputs also drain while new slots enter. The bench provokes this with unbroken runs of full random permutations, partial sets and idle slots, and with one reset that falls while cells are in flight. A scoreboard queue records each slot with its entry cycle and pops it exactly LAT cycles later. Each popped slot is judged port by port, on the valid flags and on the payload of every valid port.

// File: rtl/bb_pkg.sv
package bb_pkg;

    // setting of a 2x2 switching or compare element
    typedef enum logic {
        SW_BAR   = 1'b0,
        SW_CROSS = 1'b1
    } sw_set_e;

    // number of compare columns in a bitonic sorter over 2**lg lines
    function automatic int sort_depth(input int lg);
        return lg * (lg + 1) / 2;
    endfunction

endpackage

// File: rtl/bb_sort_cell.sv
module bb_sort_cell #(
    parameter int AW     = 3,
    parameter int W      = 16,
    parameter bit ASCEND = 1'b1,
    localparam int CW    = 1 + AW + W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] a_i,
    input  logic [CW-1:0] b_i,
    output logic [CW-1:0] lo_o,
    output logic [CW-1:0] hi_o
);
    import bb_pkg::*;

    logic [AW:0]  key_a, key_b;
    sw_set_e      set_q;

    // idle cells carry the largest key
    assign key_a = {~a_i[CW-1], a_i[CW-2 -: AW]};
    assign key_b = {~b_i[CW-1], b_i[CW-2 -: AW]};

    always_comb begin
        if (ASCEND) set_q = (key_a > key_b) ? SW_CROSS : SW_BAR;
        else        set_q = (key_a < key_b) ? SW_CROSS : SW_BAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '0;
        end else begin
            unique case (set_q)
                SW_BAR:   begin lo_o <= a_i; hi_o <= b_i; end
                SW_CROSS: begin lo_o <= b_i; hi_o <= a_i; end
                default:  begin lo_o <= a_i; hi_o <= b_i; end
            endcase
        end
    end
endmodule

// File: rtl/bb_switch2.sv
module bb_switch2 #(
    parameter int AW     = 3,
    parameter int W      = 16,
    parameter int BITSEL = 0,
    localparam int CW    = 1 + AW + W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] up_i,
    input  logic [CW-1:0] dn_i,
    output logic [CW-1:0] up_o,
    output logic [CW-1:0] dn_o
);
    import bb_pkg::*;

    logic    up_bit, dn_bit;
    sw_set_e set_q;

    assign up_bit = up_i[W + BITSEL];
    assign dn_bit = dn_i[W + BITSEL];

    // bit 0 steers to the upper line, bit 1 to the lower line
    always_comb begin
        if ((up_i[CW-1] && up_bit) || (dn_i[CW-1] && !dn_bit)) set_q = SW_CROSS;
        else                                                  set_q = SW_BAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_o <= '0;
            dn_o <= '0;
        end else begin
            unique case (set_q)
                SW_BAR:   begin up_o <= up_i; dn_o <= dn_i; end
                SW_CROSS: begin up_o <= dn_i; dn_o <= up_i; end
                default:  begin up_o <= up_i; dn_o <= dn_i; end
            endcase
        end
    end
endmodule

// File: rtl/bb_fabric.sv
module bb_fabric #(
    parameter int N  = 8,
    parameter int W  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_vld,
    input  logic [N*AW-1:0] in_dst,
    input  logic [N*W-1:0]  in_pay,
    output logic [N-1:0]    out_vld,
    output logic [N*W-1:0]  out_pay
);
    import bb_pkg::*;

    localparam int L     = AW;
    localparam int SDEP  = sort_depth(L);
    localparam int LAT   = SDEP + L;
    localparam int CW    = 1 + AW + W;

    logic [CW-1:0] srt [0:SDEP][0:N-1];
    logic [CW-1:0] ban [0:L][0:N-1];

    for (genvar gi = 0; gi < N; gi++) begin : g_pack
        assign srt[0][gi] = {in_vld[gi], in_dst[gi*AW +: AW], in_pay[gi*W +: W]};
        assign ban[0][gi] = srt[SDEP][gi];
        assign out_vld[gi]        = ban[L][gi][CW-1];
        assign out_pay[gi*W +: W] = ban[L][gi][W-1:0];
    end

    // bitonic sorter: phase gp merges blocks of 2**(gp+1)
    for (genvar gp = 0; gp < L; gp++) begin : g_phase
        for (genvar gq = 0; gq <= gp; gq++) begin : g_step
            localparam int S = gp * (gp + 1) / 2 + gq;
            localparam int D = 1 << (gp - gq);
            for (genvar gi = 0; gi < N; gi++) begin : g_cmp
                if ((gi & D) == 0) begin : g_on
                    bb_sort_cell #(
                        .AW(AW), .W(W),
                        .ASCEND(((gi >> (gp + 1)) & 1) == 0)
                    ) u_cmp (
                        .clk  (clk),
                        .rst_n(rst_n),
                        .a_i  (srt[S][gi]),
                        .b_i  (srt[S][gi + D]),
                        .lo_o (srt[S+1][gi]),
                        .hi_o (srt[S+1][gi + D])
                    );
                end
            end
        end
    end

    // butterfly: stage gs steers on destination bit L-1-gs
    for (genvar gs = 0; gs < L; gs++) begin : g_route
        localparam int D = 1 << (L - 1 - gs);
        for (genvar gi = 0; gi < N; gi++) begin : g_sw
            if ((gi & D) == 0) begin : g_on
                bb_switch2 #(
                    .AW(AW), .W(W), .BITSEL(L - 1 - gs)
                ) u_sw (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .up_i (ban[gs][gi]),
                    .dn_i (ban[gs][gi + D]),
                    .up_o (ban[gs+1][gi]),
                    .dn_o (ban[gs+1][gi + D])
                );
            end
        end
    end

endmodule

// File: rtl/bb_fabric_chk.sv
module bb_fabric_chk #(
    parameter int N   = 8,
    parameter int AW  = 3,
    parameter int LAT = 9,
    localparam int CNW = $clog2(N + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    in_vld,
    input logic [N*AW-1:0] in_dst,
    input logic [N-1:0]    out_vld
);
    logic [N-1:0]   req_mask;
    logic           dup;
    logic [CNW-1:0] req_cnt;
    logic [N-1:0]   mask_pipe [0:LAT-1];
    logic [CNW-1:0] cnt_pipe  [0:LAT-1];

    always_comb begin
        req_mask = '0;
        dup      = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (in_vld[i]) req_mask[in_dst[i*AW +: AW]] = 1'b1;
            for (int j = i + 1; j < N; j++)
                if (in_vld[i] && in_vld[j] && in_dst[i*AW +: AW] == in_dst[j*AW +: AW])
                    dup = 1'b1;
        end
    end

    assign req_cnt = CNW'($countones(in_vld));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin
                mask_pipe[k] <= '0;
                cnt_pipe[k]  <= '0;
            end
        end else begin
            mask_pipe[0] <= req_mask;
            cnt_pipe[0]  <= req_cnt;
            for (int k = 1; k < LAT; k++) begin
                mask_pipe[k] <= mask_pipe[k-1];
                cnt_pipe[k]  <= cnt_pipe[k-1];
            end
        end
    end

    // R7
    no_dup_dest_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    // R1 R2
    dest_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == mask_pipe[LAT-1]);

    // R3
    cell_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_vld) == int'(cnt_pipe[LAT-1]));

    // R8
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pipe[LAT-1] == '0) |-> (out_vld == '0));

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_vld == '0));

endmodule

bind bb_fabric bb_fabric_chk #(.N(N), .AW(AW), .LAT(LAT)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .in_dst (in_dst),
    .out_vld(out_vld)
);

// File: tb/tb_bb_fabric.sv
`timescale 1ns/1ps
module tb_bb_fabric;
    localparam int N   = 8;
    localparam int W   = 16;
    localparam int AW  = $clog2(N);
    localparam int LAT = AW * (AW + 1) / 2 + AW;   // R2

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_vld = '0;
    logic [N*AW-1:0] in_dst = '0;
    logic [N*W-1:0]  in_pay = '0;
    logic [N-1:0]    out_vld;
    logic [N*W-1:0]  out_pay;

    bb_fabric #(.N(N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_dst(in_dst), .in_pay(in_pay),
        .out_vld(out_vld), .out_pay(out_pay)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int             cyc;
        logic [N-1:0]   v;
        logic [N*W-1:0] p;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // expected values from the requirement: cell with tag d lands on port d
    task automatic slot(input logic [N-1:0] v, input logic [N*AW-1:0] d,
                        input logic [N*W-1:0] p, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = v; in_dst = d; in_pay = p;
        e.cyc = cyc; e.v = '0; e.p = '0; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                e.v[d[i*AW +: AW]] = 1'b1;
                e.p[d[i*AW +: AW]*W +: W] = p[i*W +: W];
            end
        end
        q.push_back(e);
    endtask

    // monitor: pops each slot exactly LAT edges after it entered
    always @(negedge clk) begin
        if (rst_n && q.size() > 0 && q[0].cyc + LAT == cyc) begin
            exp_t e;
            logic [N*W-1:0] got;
            e = q.pop_front();
            got = '0;
            for (int i = 0; i < N; i++)
                if (out_vld[i]) got[i*W +: W] = out_pay[i*W +: W];
            n_chk++;
            if (out_vld !== e.v || got !== e.p) begin
                n_bad++;
                $display("FAIL %s slot@%0d vld got %h exp %h pay got %h exp %h",
                         e.tag, e.cyc, out_vld, e.v, got, e.p);
            end
        end
    end

    task automatic chk_quiet(input string tag);
        n_chk++;
        if (out_vld !== '0) begin
            n_bad++;
            $display("FAIL %s vld got %h exp %h", tag, out_vld, {N{1'b0}});
        end
    endtask

    task automatic perm_slot(input logic [N-1:0] v, input string tag);
        int perm [N];
        logic [N*AW-1:0] d;
        logic [N*W-1:0]  p;
        for (int i = 0; i < N; i++) perm[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = perm[i];
            perm[i] = perm[j];
            perm[j] = t;
        end
        for (int i = 0; i < N; i++) begin
            d[i*AW +: AW] = AW'(perm[i]);
            p[i*W +: W]   = W'($urandom);
        end
        slot(v, d, p, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired, queue %0d exp 0", q.size());
            finish_run();
        end
    end

    initial begin
        logic [N*AW-1:0] d;
        logic [N*W-1:0]  p;
        repeat (3) @(negedge clk);
        chk_quiet("R4");                       // R4 outputs quiet in reset
        rst_n = 1'b1;

        // R1 identity and reversed order
        for (int i = 0; i < N; i++) begin
            d[i*AW +: AW] = AW'(i);
            p[i*W +: W]   = W'(16'h1000 + i);
        end
        slot('1, d, p, "R1");
        for (int i = 0; i < N; i++) d[i*AW +: AW] = AW'(N - 1 - i);
        slot('1, d, p, "R5");

        // R1 one cell alone from every input to every output
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++) begin
                d = '0; p = '0;
                d[s*AW +: AW] = AW'(t);
                p[s*W +: W]   = W'(16'hA000 + s * 16 + t);
                slot(N'(1) << s, d, p, "R1");
            end

        // R8 idle slot between traffic
        slot('0, '0, '0, "R8");

        // R5 sparse set that collides in a lone butterfly: 0->0, 4->1
        d = '0; p = '0;
        d[0*AW +: AW] = AW'(0); p[0*W +: W] = 16'h0BAD;
        d[4*AW +: AW] = AW'(1); p[4*W +: W] = 16'h4CAF;
        slot(N'(8'h11), d, p, "R5");

        // R6 back-to-back full permutations
        for (int k = 0; k < 40; k++) perm_slot('1, "R6");

        // R3 partial sets with random gaps
        for (int k = 0; k < 60; k++) perm_slot(N'($urandom), "R3");

        // R4 reset with cells in flight
        for (int k = 0; k < 4; k++) perm_slot('1, "R4");
        @(negedge clk);
        in_vld = '0;
        rst_n  = 1'b0;
        q.delete();
        #1;
        chk_quiet("R4");
        @(negedge clk);
        chk_quiet("R4");
        rst_n = 1'b1;

        // R6 traffic resumes after reset, mixed with idle slots (R8)
        for (int k = 0; k < 20; k++) begin
            perm_slot('1, "R6");
            if (k % 5 == 0) slot('0, '0, '0, "R8");
        end

        for (int k = 0; k < LAT + 2; k++) slot('0, '0, '0, "R8");
        repeat (LAT + 2) @(negedge clk);
        if (q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2 undrained queue got %0d exp 0", q.size());
        end
        finish_run();
    end
endmodule